// File: doc/BRIEF.md
# Dual-Issue Pairing Checker

This block sits at the first decode stage of an in-order integer core that has two pipes. Each cycle it receives two decoded instruction descriptors in program order. The older one is in slot 0 and the younger one is in slot 1. The block decides whether both can leave together, the older one down the primary pipe U and the younger one down the secondary pipe V, or whether only the older one leaves. When only the older one leaves, the front end shifts the younger descriptor into slot 0 on the next cycle and fetches a new one behind it. The block reports how many slots it consumed so that the front end can do this shift.

Each descriptor carries a valid bit, two source register fields, a destination register field and four flags. The flags mark a displacement operand, an immediate operand, a floating-point operation, and a complex operation that only the U pipe can execute. The block computes the decision combinationally and registers it at the stage boundary as the U and V issue bits and a 3-bit reason code.

The block also ties the two pipes together while a pair is in flight. A stall from either pipe freezes the whole stage, so that the two instructions of a pair advance in lockstep.

Top module: `dual_issue_pair`

## Requirements
- R1: When both slots are valid and no other rule refuses them, both issue (`issue_u`=1, `issue_v`=1) and `pair_reason` is 0.
- R2: If either source field of the younger instruction equals a nonzero destination field of the older one, only U issues and `pair_reason` is 5.
- R3: If both instructions name the same nonzero destination, only U issues and `pair_reason` is 6.
- R4: A register field of value 0 means "no register" and never creates a dependency.
- R5: If either instruction carries a displacement or an immediate operand, only U issues and `pair_reason` is 3.
- R6: If exactly one of the two instructions is floating-point, only U issues and `pair_reason` is 4. Two floating-point instructions may pair.
- R7: If the younger instruction is complex, only U issues and `pair_reason` is 2. A complex older instruction may still pair.
- R8: If the older slot is valid and the younger slot is invalid, only U issues. If the older slot is invalid, nothing issues. In both cases `pair_reason` is 1.
- R9: When several rules refuse at once, the reported code is the first that applies in this order: 1, 2, 3, 4, 5, 6.
- R10: The issue bits and `pair_reason` are registered and change one clock after the inputs. After reset they read `issue_u`=0, `issue_v`=0 and `pair_reason`=1.
- R11: `take_cnt` is combinational and equals the number of instructions the current inputs will issue. It is 0 whenever `freeze` is high.
- R12: `freeze` = `stall_u` OR (`stall_v` AND `issue_v`). While `freeze` is high, the registered outputs hold their values.
- R13: `stall_v` has no effect while only a single instruction is in flight (`issue_v`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s0_valid | input | 1 | Older slot holds an instruction |
| s0_src_a | input | REG_W | Older first source register |
| s0_src_b | input | REG_W | Older second source register |
| s0_dst | input | REG_W | Older destination register |
| s0_disp | input | 1 | Older has a displacement operand |
| s0_imm | input | 1 | Older has an immediate operand |
| s0_fp | input | 1 | Older is floating-point |
| s0_cplx | input | 1 | Older is complex (U only) |
| s1_valid | input | 1 | Younger slot holds an instruction |
| s1_src_a | input | REG_W | Younger first source register |
| s1_src_b | input | REG_W | Younger second source register |
| s1_dst | input | REG_W | Younger destination register |
| s1_disp | input | 1 | Younger has a displacement operand |
| s1_imm | input | 1 | Younger has an immediate operand |
| s1_fp | input | 1 | Younger is floating-point |
| s1_cplx | input | 1 | Younger is complex |
| stall_u | input | 1 | U pipe cannot advance |
| stall_v | input | 1 | V pipe cannot advance |
| issue_u | output | 1 | Registered: an instruction went to U |
| issue_v | output | 1 | Registered: an instruction went to V |
| pair_reason | output | 3 | Registered reason code (see R1 to R9) |
| take_cnt | output | 2 | Slots consumed this cycle |
| freeze | output | 1 | Whole stage held this cycle |

## Verification
Two things can happen in the same cycle: a new pairing decision is presented, and a stall arrives from the V pipe behind a pair that is already in flight. The bench provokes this by issuing a clean pair and then, on the next cycle, presenting a dependent pair while raising `stall_v`. It judges the outcome by `freeze` rising, `take_cnt` reading 0, and the registered pair outputs staying unchanged across the edge. It then drops the stall and checks that the held decision finally registers. It repeats the same `stall_v` stimulus behind a single instruction to show that the stall is ignored there.

// File: rtl/pair_pkg.sv
package pair_pkg;

    typedef enum logic [2:0] {
        RSN_PAIRED   = 3'd0,
        RSN_EMPTY    = 3'd1,
        RSN_CPLX_V   = 3'd2,
        RSN_OPERAND  = 3'd3,
        RSN_FP_MIX   = 3'd4,
        RSN_RAW      = 3'd5,
        RSN_WAW      = 3'd6
    } reason_e;

    typedef struct packed {
        logic disp;
        logic imm;
        logic fp;
        logic cplx;
    } flags_t;

    typedef struct packed {
        logic    iss_u;
        logic    iss_v;
        reason_e reason;
    } stage_t;

endpackage

// File: rtl/pair_dep_check.sv
module pair_dep_check #(
    parameter int REG_W = 5,
    parameter int NSRC  = 2
) (
    input  logic [REG_W-1:0]            old_dst,
    input  logic [NSRC-1:0][REG_W-1:0]  yng_src,
    input  logic [REG_W-1:0]            yng_dst,
    output logic                        raw,
    output logic                        waw
);
    localparam logic [REG_W-1:0] NO_REG = '0;

    logic [NSRC-1:0] src_hit;

    // one comparator per younger source; register 0 never matches
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign src_hit[i] = (yng_src[i] != NO_REG) && (yng_src[i] == old_dst);
    end

    assign raw = |src_hit;
    assign waw = (old_dst != NO_REG) && (yng_dst == old_dst);

endmodule

// File: rtl/pair_rules.sv
module pair_rules
    import pair_pkg::*;
(
    input  logic    old_valid,
    input  logic    yng_valid,
    input  flags_t  old_flags,
    input  flags_t  yng_flags,
    input  logic    raw,
    input  logic    waw,
    output logic    dec_u,
    output logic    dec_v,
    output reason_e reason
);
    always_comb begin
        dec_u  = old_valid;
        dec_v  = 1'b0;
        reason = RSN_PAIRED;
        if (!old_valid || !yng_valid)
            reason = RSN_EMPTY;
        else if (yng_flags.cplx)
            reason = RSN_CPLX_V;
        else if (old_flags.disp || old_flags.imm || yng_flags.disp || yng_flags.imm)
            reason = RSN_OPERAND;
        else if (old_flags.fp != yng_flags.fp)
            reason = RSN_FP_MIX;
        else if (raw)
            reason = RSN_RAW;
        else if (waw)
            reason = RSN_WAW;
        else
            dec_v = 1'b1;
    end

endmodule

// File: rtl/dual_issue_pair.sv
module dual_issue_pair
    import pair_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s0_valid,
    input  logic [REG_W-1:0] s0_src_a,
    input  logic [REG_W-1:0] s0_src_b,
    input  logic [REG_W-1:0] s0_dst,
    input  logic             s0_disp,
    input  logic             s0_imm,
    input  logic             s0_fp,
    input  logic             s0_cplx,
    input  logic             s1_valid,
    input  logic [REG_W-1:0] s1_src_a,
    input  logic [REG_W-1:0] s1_src_b,
    input  logic [REG_W-1:0] s1_dst,
    input  logic             s1_disp,
    input  logic             s1_imm,
    input  logic             s1_fp,
    input  logic             s1_cplx,
    input  logic             stall_u,
    input  logic             stall_v,
    output logic             issue_u,
    output logic             issue_v,
    output logic [2:0]       pair_reason,
    output logic [1:0]       take_cnt,
    output logic             freeze
);
    localparam int NSRC = 2;

    logic    raw, waw, dec_u, dec_v;
    reason_e dec_reason;
    stage_t  st_d, st_q;

    pair_dep_check #(.REG_W(REG_W), .NSRC(NSRC)) u_dep (
        .old_dst (s0_dst),
        .yng_src ({s1_src_b, s1_src_a}),
        .yng_dst (s1_dst),
        .raw     (raw),
        .waw     (waw)
    );

    pair_rules u_rules (
        .old_valid (s0_valid),
        .yng_valid (s1_valid),
        .old_flags ('{disp: s0_disp, imm: s0_imm, fp: s0_fp, cplx: s0_cplx}),
        .yng_flags ('{disp: s1_disp, imm: s1_imm, fp: s1_fp, cplx: s1_cplx}),
        .raw       (raw),
        .waw       (waw),
        .dec_u     (dec_u),
        .dec_v     (dec_v),
        .reason    (dec_reason)
    );

    // a stall from either pipe holds a pair; V alone matters only for a pair
    assign freeze = stall_u | (stall_v & st_q.iss_v);

    always_comb begin
        st_d     = st_q;
        take_cnt = 2'd0;
        if (!freeze) begin
            st_d.iss_u  = dec_u;
            st_d.iss_v  = dec_v;
            st_d.reason = dec_reason;
            take_cnt    = {1'b0, dec_u} + {1'b0, dec_v};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.iss_u  <= 1'b0;
            st_q.iss_v  <= 1'b0;
            st_q.reason <= RSN_EMPTY;
        end else begin
            st_q <= st_d;
        end
    end

    assign issue_u     = st_q.iss_u;
    assign issue_v     = st_q.iss_v;
    assign pair_reason = st_q.reason;

    // R12
    hold_on_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> $stable(st_q));

    // R1
    v_needs_u_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.iss_v |-> st_q.iss_u);

    // R1
    pair_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.iss_v |-> (st_q.reason == RSN_PAIRED));

    // R11
    no_take_in_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |-> (take_cnt == 2'd0));

    // R2
    raw_blocks_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!freeze && s0_valid && s1_valid && raw) |=> !st_q.iss_v);

    // R8
    empty_older_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!freeze && !s0_valid) |=> (!st_q.iss_u && !st_q.iss_v));

endmodule

// File: tb/tb_dual_issue_pair.sv
module tb_dual_issue_pair;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       s0_valid, s0_disp, s0_imm, s0_fp, s0_cplx;
    logic       s1_valid, s1_disp, s1_imm, s1_fp, s1_cplx;
    logic [4:0] s0_src_a, s0_src_b, s0_dst, s1_src_a, s1_src_b, s1_dst;
    logic       stall_u, stall_v;
    logic       issue_u, issue_v, freeze;
    logic [2:0] pair_reason;
    logic [1:0] take_cnt;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    dual_issue_pair #(.REG_W(5)) dut (.*);

    // descriptor: {valid, src_a, src_b, dst, disp, imm, fp, cplx} = 20 bits
    // vector: {req[3:0], d0[19:0], d1[19:0], exp_u, exp_v, exp_reason[2:0]}
    localparam int NV = 17;
    localparam logic [48:0] VECS [NV] = '{
        {4'd1,  1'b1,5'd1,5'd2,5'd3,4'b0000, 1'b1,5'd4,5'd5,5'd6,4'b0000, 1'b1,1'b1,3'd0}, // R1
        {4'd2,  1'b1,5'd1,5'd2,5'd3,4'b0000, 1'b1,5'd3,5'd5,5'd6,4'b0000, 1'b1,1'b0,3'd5}, // R2 src_a
        {4'd2,  1'b1,5'd1,5'd2,5'd3,4'b0000, 1'b1,5'd4,5'd3,5'd6,4'b0000, 1'b1,1'b0,3'd5}, // R2 src_b
        {4'd3,  1'b1,5'd1,5'd2,5'd3,4'b0000, 1'b1,5'd4,5'd5,5'd3,4'b0000, 1'b1,1'b0,3'd6}, // R3
        {4'd4,  1'b1,5'd1,5'd2,5'd0,4'b0000, 1'b1,5'd0,5'd0,5'd0,4'b0000, 1'b1,1'b1,3'd0}, // R4
        {4'd5,  1'b1,5'd1,5'd2,5'd3,4'b1000, 1'b1,5'd4,5'd5,5'd6,4'b0000, 1'b1,1'b0,3'd3}, // R5 disp
        {4'd5,  1'b1,5'd1,5'd2,5'd3,4'b0000, 1'b1,5'd4,5'd5,5'd6,4'b0100, 1'b1,1'b0,3'd3}, // R5 imm
        {4'd6,  1'b1,5'd1,5'd2,5'd3,4'b0010, 1'b1,5'd4,5'd5,5'd6,4'b0000, 1'b1,1'b0,3'd4}, // R6 mix
        {4'd6,  1'b1,5'd1,5'd2,5'd3,4'b0010, 1'b1,5'd4,5'd5,5'd6,4'b0010, 1'b1,1'b1,3'd0}, // R6 both fp
        {4'd7,  1'b1,5'd1,5'd2,5'd3,4'b0001, 1'b1,5'd4,5'd5,5'd6,4'b0000, 1'b1,1'b1,3'd0}, // R7 older
        {4'd7,  1'b1,5'd1,5'd2,5'd3,4'b0000, 1'b1,5'd4,5'd5,5'd6,4'b0001, 1'b1,1'b0,3'd2}, // R7 younger
        {4'd8,  1'b1,5'd1,5'd2,5'd3,4'b0000, 1'b0,5'd4,5'd5,5'd6,4'b0000, 1'b1,1'b0,3'd1}, // R8 single
        {4'd8,  1'b0,5'd1,5'd2,5'd3,4'b0000, 1'b1,5'd4,5'd5,5'd6,4'b0000, 1'b0,1'b0,3'd1}, // R8 none
        {4'd9,  1'b1,5'd1,5'd2,5'd3,4'b0000, 1'b1,5'd3,5'd0,5'd6,4'b0101, 1'b1,1'b0,3'd2}, // R9
        {4'd9,  1'b1,5'd1,5'd2,5'd3,4'b1010, 1'b1,5'd3,5'd5,5'd6,4'b0000, 1'b1,1'b0,3'd3}, // R9
        {4'd9,  1'b1,5'd1,5'd2,5'd3,4'b0010, 1'b1,5'd3,5'd5,5'd6,4'b0000, 1'b1,1'b0,3'd4}, // R9
        {4'd9,  1'b1,5'd1,5'd2,5'd3,4'b0000, 1'b1,5'd3,5'd0,5'd3,4'b0000, 1'b1,1'b0,3'd5}  // R9
    };

    task automatic drive(input logic [48:0] v);
        {s0_valid, s0_src_a, s0_src_b, s0_dst, s0_disp, s0_imm, s0_fp, s0_cplx} = v[44:25];
        {s1_valid, s1_src_a, s1_src_b, s1_dst, s1_disp, s1_imm, s1_fp, s1_cplx} = v[24:5];
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_regs(input string req, input int u, input int v, input int r);
        chk({req, " issue_u"}, issue_u, u);
        chk({req, " issue_v"}, issue_v, v);
        chk({req, " pair_reason"}, pair_reason, r);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; stall_u = 1'b0; stall_v = 1'b0;
        drive(VECS[0]);
        repeat (3) @(negedge clk);
        chk_regs("R10 reset", 0, 0, 1);
        rst_n = 1'b1;

        // table walk: drive at a falling edge, judge at the next one
        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VECS[i][48:45], i);
            drive(VECS[i]);
            #1;
            chk({"R11 ", tag, " take_cnt"}, take_cnt, VECS[i][4] + VECS[i][3]);
            @(negedge clk);
            chk_regs({"R10 ", tag}, VECS[i][4], VECS[i][3], VECS[i][2:0]);
        end

        // pair in flight, then stall_v arrives with a dependent pair
        drive(VECS[0]);
        @(negedge clk);
        chk_regs("R1 pair before stall", 1, 1, 0);
        drive(VECS[1]); stall_v = 1'b1;
        #1;
        chk("R12 freeze on stall_v with pair", freeze, 1);
        chk("R11 take_cnt while frozen", take_cnt, 0);
        @(negedge clk);
        chk_regs("R12 pair held", 1, 1, 0);
        stall_v = 1'b0;
        #1;
        chk("R12 freeze released", freeze, 0);
        @(negedge clk);
        chk_regs("R12 held decision registers", 1, 0, 5);

        // single in flight: stall_v is ignored
        drive(VECS[0]); stall_v = 1'b1;
        #1;
        chk("R13 no freeze behind single", freeze, 0);
        chk("R13 take_cnt behind single", take_cnt, 2);
        @(negedge clk);
        chk_regs("R13 decision still advances", 1, 1, 0);

        // stall_u freezes regardless
        stall_v = 1'b0; stall_u = 1'b1;
        drive(VECS[11]);
        #1;
        chk("R12 freeze on stall_u", freeze, 1);
        @(negedge clk);
        chk_regs("R12 hold under stall_u", 1, 1, 0);
        stall_u = 1'b0;
        @(negedge clk);
        chk_regs("R8 after stall_u release", 1, 0, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule